// File: doc/BRIEF.md
# Control-Word Driven Warp Issue Stage

This block sits between instruction fetch and execute for a single warp. Fetch hands it a bundle of four 64-bit instructions and one 64-bit scheduling word. The scheduling word holds four 16-bit fields, one per instruction. The block sends the four instructions to an execute port one at a time, in slot order. Before each release it applies the timing and ordering hints that the compiler placed in that instruction's field. The block does not look for hazards itself. All ordering comes from these static hints.

Each field carries four hints:

- a minimum gap in cycles before the next instruction may go;
- a hint that an external warp arbiter may switch away;
- a token that the instruction raises when it issues;
- the tokens that the instruction must see cleared before it goes.

Tokens stand for long-running operations whose finish time is unknown. A completion port lowers them. One bundle is 320 bits: four instructions plus the scheduling word.

Top module: `cw_issue_stage`

## Requirements
- R1: `grp_ready` is high exactly when no bundle is held. A bundle is captured on `grp_valid && grp_ready`, and `grp_ready` is low in the next cycle.
- R2: Slots go out in the order 0, 1, 2, 3. Slot i is bundle bits [64*i+63 : 64*i]. Its field is bundle bits [256+16*i+15 : 256+16*i].
- R3: The 16-bit field layout is:
  - gap count in bits [3:0];
  - yield hint in bit 4;
  - read token index in bits [7:5];
  - write token index in bits [10:8];
  - wait mask in bits [15:11], where bit 11+k selects token k for k = 0 to 4.
- R4: Take an instruction whose gap count is S, released at edge t. The next release happens no earlier than edge t+max(S,1). With no other hold, it happens exactly there. At most one instruction goes per cycle.
- R5: `yield_req` is high for exactly the cycle in which a newly released instruction with the yield hint first appears on `exe_valid`.
- R6: Releasing an instruction whose write index is 0 to 5 raises that token from the next cycle on. Index 6 or 7 raises nothing.
- R7: A `done_valid` pulse whose `done_idx` is 0 to 5 lowers that token from the next cycle on. If a release raises the same token in the same cycle, the raise wins.
- R8: An instruction is held while any token it needs is raised. It needs the tokens picked by its wait mask and the token named by its read index; a read index of 6 or 7 names none. A token lowered in a cycle unblocks release one cycle later.
- R9: While `exe_valid` is high and `exe_ready` is low, `exe_valid` stays high and `exe_instr` keeps its value.
- R10: After reset, `exe_valid` and `yield_req` are 0, all tokens are lowered, and `grp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | Fetch offers a bundle |
| grp_ready | output | 1 | Block can take a bundle |
| grp_data | input | 320 | Four instructions plus the scheduling word |
| exe_valid | output | 1 | An instruction is offered to execute |
| exe_ready | input | 1 | Execute takes the offered instruction |
| exe_instr | output | 64 | Offered instruction |
| done_valid | input | 1 | A long-running operation has finished |
| done_idx | input | 3 | Token lowered by that completion |
| yield_req | output | 1 | Hint to the warp arbiter that switching is cheap |

## Verification
Two token events can fall in the same cycle. A release can raise a token while a completion lowers that same token, and a completion can lower a token that the instruction under consideration is waiting on.

The bench drives a completion strobe with a random index on about half of all cycles. Random bundles use write, read and mask fields over the full index range, so both kinds of overlap happen many times.

A behavioural model in the bench applies the set-wins rule and the one-cycle unblock latency. It predicts every release cycle, and each cycle's outputs are compared with that prediction.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int CW_FIELD_W = 16;
  localparam int CW_GAP_W   = 4;
  localparam int CW_IDX_W   = 3;
  localparam int CW_WMASK_W = CW_FIELD_W - CW_GAP_W - 1 - 2 * CW_IDX_W;

  typedef struct packed {
    logic [CW_WMASK_W-1:0] wmask;
    logic [CW_IDX_W-1:0]   wr;
    logic [CW_IDX_W-1:0]   rd;
    logic                  yld;
    logic [CW_GAP_W-1:0]   gap;
  } ctl_field_t;
endpackage

// File: rtl/cw_slot_decode.sv
module cw_slot_decode
  import cw_pkg::*;
#(
  parameter int INSTR_W = 64,
  parameter int SLOTS   = 4,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int BUNDLE_W = (INSTR_W + CW_FIELD_W) * SLOTS
) (
  input  logic [BUNDLE_W-1:0] bundle,
  input  logic [SLOT_W-1:0]   slot,
  output logic [INSTR_W-1:0]  instr,
  output ctl_field_t          fld
);
  logic [INSTR_W-1:0]    lane [SLOTS];
  logic [CW_FIELD_W-1:0] ctl  [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_lane
    assign lane[g] = bundle[g*INSTR_W +: INSTR_W];
    assign ctl[g]  = bundle[INSTR_W*SLOTS + g*CW_FIELD_W +: CW_FIELD_W];
  end

  assign instr = lane[slot];
  assign fld   = ctl_field_t'(ctl[slot]);
endmodule

// File: rtl/cw_token_board.sv
module cw_token_board #(
  parameter int NTOK  = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NTOK-1:0]  tok
);
  for (genvar g = 0; g < NTOK; g++) begin : g_tok
    logic t_q;
    always_ff @(posedge clk) begin
      if (rst)                                      t_q <= 1'b0;
      else if (set_en && set_idx == IDX_W'(g))      t_q <= 1'b1;
      else if (clr_en && clr_idx == IDX_W'(g))      t_q <= 1'b0;
    end
    assign tok[g] = t_q;
  end
endmodule

// File: rtl/cw_stall_timer.sv
module cw_stall_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] span,
  output logic             ok
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= (span == '0) ? '0 : span - 1'b1;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign ok = (cnt_q == '0);
endmodule

// File: rtl/cw_issue_stage.sv
module cw_issue_stage
  import cw_pkg::*;
#(
  parameter int INSTR_W = 64,
  parameter int SLOTS   = 4,
  parameter int NTOK    = 6,
  localparam int BUNDLE_W = (INSTR_W + CW_FIELD_W) * SLOTS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                grp_valid,
  output logic                grp_ready,
  input  logic [BUNDLE_W-1:0] grp_data,
  output logic                exe_valid,
  input  logic                exe_ready,
  output logic [INSTR_W-1:0]  exe_instr,
  input  logic                done_valid,
  input  logic [CW_IDX_W-1:0] done_idx,
  output logic                yield_req
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [BUNDLE_W-1:0] grp_q;
  logic                grp_full;
  logic [SLOT_W-1:0]   slot_q;
  logic [INSTR_W-1:0]  cur_instr;
  ctl_field_t          cur_fld;
  logic [NTOK-1:0]     tok, need;
  logic                blocked, timer_ok, iss_fire;
  logic [CW_IDX_W-1:0] iss_wr;

  cw_slot_decode #(.INSTR_W(INSTR_W), .SLOTS(SLOTS)) u_dec (
    .bundle(grp_q), .slot(slot_q), .instr(cur_instr), .fld(cur_fld)
  );

  // Tokens this slot depends on: mask bits plus the read index.
  for (genvar g = 0; g < NTOK; g++) begin : g_need
    if (g < CW_WMASK_W) begin : g_m
      assign need[g] = cur_fld.wmask[g] | (cur_fld.rd == CW_IDX_W'(g));
    end else begin : g_r
      assign need[g] = (cur_fld.rd == CW_IDX_W'(g));
    end
  end

  assign blocked   = |(need & tok);
  assign grp_ready = ~grp_full;
  assign iss_fire  = grp_full && timer_ok && !blocked && (!exe_valid || exe_ready);
  assign iss_wr    = cur_fld.wr;

  cw_token_board #(.NTOK(NTOK), .IDX_W(CW_IDX_W)) u_tok (
    .clk(clk), .rst(rst),
    .set_en(iss_fire), .set_idx(iss_wr),
    .clr_en(done_valid), .clr_idx(done_idx),
    .tok(tok)
  );

  cw_stall_timer #(.CNT_W(CW_GAP_W)) u_gap (
    .clk(clk), .rst(rst), .load(iss_fire), .span(cur_fld.gap), .ok(timer_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_full  <= 1'b0;
      slot_q    <= '0;
      exe_valid <= 1'b0;
      yield_req <= 1'b0;
    end else begin
      if (iss_fire) begin
        exe_valid <= 1'b1;
        yield_req <= cur_fld.yld;
        if (slot_q == LAST_SLOT) begin
          grp_full <= 1'b0;
          slot_q   <= '0;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else begin
        yield_req <= 1'b0;
        if (exe_ready) exe_valid <= 1'b0;
      end
      if (grp_valid && !grp_full) begin
        grp_full <= 1'b1;
        slot_q   <= '0;
      end
    end
  end

  // Data registers carry no reset so they map onto plain fabric flops.
  always_ff @(posedge clk) begin
    if (iss_fire) exe_instr <= cur_instr;
    if (grp_valid && !grp_full) grp_q <= grp_data;
  end
endmodule

// File: rtl/cw_issue_checks.sv
module cw_issue_checks #(
  parameter int NTOK  = 6,
  parameter int IDX_W = 3,
  parameter int INSTR_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               grp_valid,
  input logic               grp_ready,
  input logic               exe_valid,
  input logic               exe_ready,
  input logic [INSTR_W-1:0] exe_instr,
  input logic               yield_req,
  input logic               done_valid,
  input logic [IDX_W-1:0]   done_idx,
  input logic               fire,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [NTOK-1:0]    tok,
  input logic [NTOK-1:0]    need
);
  localparam logic [IDX_W-1:0] NTOK_IDX = IDX_W'(NTOK);

  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    (grp_valid && grp_ready) |=> !grp_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (exe_valid && !exe_ready) |=> (exe_valid && $stable(exe_instr)));

  assert_yield_R5: assert property (@(posedge clk) disable iff (rst)
    yield_req |-> exe_valid);

  assert_set_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && wr_idx < NTOK_IDX) |=> tok[$past(wr_idx)]);

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_idx < NTOK_IDX && !(fire && wr_idx == done_idx))
      |=> !tok[$past(done_idx)]);

  assert_block_R8: assert property (@(posedge clk) disable iff (rst)
    fire |-> ((need & tok) == '0));
endmodule

bind cw_issue_stage cw_issue_checks #(.NTOK(NTOK), .IDX_W(cw_pkg::CW_IDX_W), .INSTR_W(INSTR_W)) u_chk (
  .clk(clk), .rst(rst),
  .grp_valid(grp_valid), .grp_ready(grp_ready),
  .exe_valid(exe_valid), .exe_ready(exe_ready), .exe_instr(exe_instr),
  .yield_req(yield_req),
  .done_valid(done_valid), .done_idx(done_idx),
  .fire(iss_fire), .wr_idx(iss_wr), .tok(tok), .need(need)
);

// File: tb/tb_cw_issue_stage.sv
`timescale 1ns/1ps
module tb_cw_issue_stage;
  localparam int NG = 160;

  logic         clk = 1'b0;
  logic         rst;
  logic         grp_valid, grp_ready, exe_valid, exe_ready, done_valid, yield_req;
  logic [319:0] grp_data;
  logic [63:0]  exe_instr;
  logic [2:0]   done_idx;

  always #4 clk = ~clk;

  cw_issue_stage dut (
    .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_ready(grp_ready),
    .grp_data(grp_data), .exe_valid(exe_valid), .exe_ready(exe_ready),
    .exe_instr(exe_instr), .done_valid(done_valid), .done_idx(done_idx),
    .yield_req(yield_req)
  );

  bit [319:0] grps [NG];
  int ngrp, gi, vectors, misses;

  // Behavioural reference state
  bit         m_full, m_v, m_y;
  int         m_slot, m_cnt;
  bit [5:0]   m_tok;
  bit [63:0]  m_instr;
  bit [319:0] m_grp;

  function automatic bit [15:0] fld(int gap, bit y, int rd, int wr, int wm);
    return {5'(wm), 3'(wr), 3'(rd), y, 4'(gap)};  // R3 field layout
  endfunction

  function automatic bit [319:0] mkg(int tag, bit [15:0] f0, bit [15:0] f1, bit [15:0] f2, bit [15:0] f3);
    bit [319:0] b;
    for (int i = 0; i < 4; i++) b[64*i +: 64] = {32'hC0DE0000 + 32'(tag), 32'(i * 4099 + tag * 17)};
    b[256 +: 64] = {f3, f2, f1, f0};  // R2 field placement
    return b;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_full = 0; m_v = 0; m_y = 0; m_slot = 0; m_cnt = 0; m_tok = '0; gi = gi;
    end else begin
      bit [15:0] f; bit blk, fire, was_full; bit [5:0] nt;
      was_full = m_full;
      f = m_grp[256 + 16*m_slot +: 16];
      blk = 0;
      for (int k = 0; k < 5; k++) if (f[11+k] && m_tok[k]) blk = 1;
      if (f[7:5] < 6 && m_tok[f[7:5]]) blk = 1;           // R8
      fire = m_full && (m_cnt == 0) && !blk && (!m_v || exe_ready);
      nt = m_tok;
      if (done_valid && done_idx < 6) nt[done_idx] = 0;     // R7 clear
      if (fire && f[10:8] < 6) nt[f[10:8]] = 1;             // R6 set, wins over R7
      if (fire) begin
        m_v = 1; m_instr = m_grp[64*m_slot +: 64]; m_y = f[4];
        m_cnt = (f[3:0] == 0) ? 0 : int'(f[3:0]) - 1;       // R4
        if (m_slot == 3) begin m_full = 0; m_slot = 0; end else m_slot++;
      end else begin
        m_y = 0;
        if (exe_ready) m_v = 0;
        if (m_cnt > 0) m_cnt--;
      end
      m_tok = nt;
      if (grp_valid && !was_full) begin
        m_grp = grp_data; m_full = 1; m_slot = 0; gi++;
      end
    end
  end

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(exe_valid === m_v, "R4 R6 R7 R8 R9 exe_valid", 64'(exe_valid), 64'(m_v));
    if (m_v) chk(exe_instr === m_instr, "R2 R3 exe_instr", exe_instr, m_instr);
    chk(yield_req === m_y, "R5 yield_req", 64'(yield_req), 64'(m_y));
    chk(grp_ready === !m_full, "R1 grp_ready", 64'(grp_ready), 64'(!m_full));
  endtask

  initial begin
    int cyc, tail; bit rnd_ready;
    rst = 1; grp_valid = 0; grp_data = '0; exe_ready = 1; done_valid = 0; done_idx = 0;
    gi = 0; vectors = 0; misses = 0; ngrp = 0; cyc = 0; tail = 0; rnd_ready = 0;
    // Directed bundles
    grps[ngrp++] = mkg(1, fld(1,0,7,7,0), fld(1,0,7,7,0), fld(1,0,7,7,0), fld(1,0,7,7,0));
    grps[ngrp++] = mkg(2, fld(0,1,7,7,0), fld(5,0,7,7,0), fld(15,1,7,7,0), fld(2,0,7,7,0));
    grps[ngrp++] = mkg(3, fld(1,0,7,2,0), fld(1,0,7,7,4), fld(1,0,7,5,0), fld(1,1,5,7,0));
    grps[ngrp++] = mkg(4, fld(1,0,7,6,0), fld(1,0,6,7,0), fld(1,0,7,7,0), fld(3,0,7,3,0));
    grps[ngrp++] = mkg(5, fld(1,0,7,3,0), fld(1,0,7,7,8), fld(0,0,7,3,0), fld(1,1,3,7,0));
    while (ngrp < NG) begin
      bit [15:0] f [4];
      for (int i = 0; i < 4; i++)
        f[i] = fld($urandom % 6, 1'($urandom), $urandom % 8, $urandom % 8,
                   ($urandom % 4 == 0) ? $urandom % 32 : 0);
      grps[ngrp] = mkg(ngrp + 1, f[0], f[1], f[2], f[3]);
      ngrp++;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(exe_valid === 1'b0, "R10 exe_valid after reset", 64'(exe_valid), 64'd0);
    chk(yield_req === 1'b0, "R10 yield_req after reset", 64'(yield_req), 64'd0);
    chk(grp_ready === 1'b1, "R10 grp_ready after reset", 64'(grp_ready), 64'd1);
    while (tail < 40) begin
      compare_all();
      if (gi >= 5) rnd_ready = 1;
      grp_valid  = (gi < ngrp);
      grp_data   = grps[(gi < ngrp) ? gi : 0];
      exe_ready  = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
      done_valid = 1'($urandom);
      done_idx   = 3'($urandom);
      if (gi >= ngrp && !m_full && !m_v) tail++;
      cyc++;
      if (cyc > 60000) begin
        misses++; vectors++;
        $display("FAIL watchdog R8 progress actual=hung expected=drained");
        break;
      end
      @(negedge clk);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule